// File: doc/BRIEF.md
# SDRAM Burst Read Engine

This engine moves a run of sequential words out of one bank of a single-data-rate SDRAM. A job gives a start row, a start column, a bank and a burst count. The engine accepts the job over a valid/ready handshake and asks an external arbiter for the memory bus. Once the arbiter grants the bus, the engine opens the row and waits the activate-to-column delay. It then issues back-to-back four-word READ commands, with the column advancing by four for each one. Returned words are picked off the data bus after the selected CAS latency and come out on a read stream.

The engine closes the bank with a precharge-all in three cases: the job is finished, a refresh is waiting at a burst boundary, or the read sink has no room. After the precharge wait it either reports completion or yields the bus with a break pulse. A yield keeps the row and column cursor, so the next grant continues at the burst that would have come next. When a row runs out of columns, the engine keeps the bus, precharges, opens the following row and carries on from column zero.

The read stream has no ready input. Back-pressure works at burst granularity through `sink_room`. While it is high, the sink promises to absorb every word of each burst already issued. The engine samples it before requesting the bus and at every burst boundary.

Top module: `sdram_burst_reader`

## Requirements
- R1: Out of reset the command bus is NOP, `arb_req`, `rd_valid`, `xfer_done` and `yield_pulse` are low, and `job_ready` is high.
- R2: `sd_cmd` is {chip select, row strobe, column strobe, write enable}, all active low. The only codes driven are NOP=0111, ACTIVE=0011, READ=0101 and PRECHARGE=0010.
- R3: A job is taken when `job_valid` and `job_ready` are both high. `job_ready` is low from the cycle after acceptance until the engine is idle again.
- R4: `arb_req` is high only while a job is waiting for the bus and `sink_room` is high. It is low in the cycle after a cycle where both `arb_req` and `arb_grant` were high.
- R5: A grant produces ACTIVE with the row on `sd_addr`. The first READ after any ACTIVE comes exactly TRCD cycles later (default 3).
- R6: READ commands within one open row are exactly 4 cycles apart. Each carries the column on `sd_addr[8:0]` with `sd_addr[10]` low. The first column is the job column with its two low bits cleared, and each later column is 4 higher. `sd_bank` holds the job bank.
- R7: A burst's four words are on `sd_dq` CL cycles after its READ, with CL=3 when `cl3` is high and CL=2 otherwise. Each word appears on `rd_data` with `rd_valid` one cycle after it was on `sd_dq`, in address order.
- R8: After a READ of column 508, the engine precharges and issues ACTIVE for the next row (8191 wraps to 0) exactly TRP cycles (default 2) after the PRECHARGE, then continues at column 0.
- R9: If `refresh_pending` is high at a burst boundary, no further READ is issued. PRECHARGE follows and `yield_pulse` rises TRP cycles after it. At most one READ follows the first clock edge that sees the refresh.
- R10: `sink_room` low at a burst boundary yields the bus in the same way as R9, and `arb_req` stays low while `sink_room` is low.
- R11: After a yield, the next grant activates the saved row. Reading resumes at the next unread column, so the stream holds exactly 4×(`job_bursts`+1) words with no gap or repeat.
- R12: After the final burst, the engine precharges and `xfer_done` pulses TRP cycles after the PRECHARGE. Exactly `job_bursts`+1 READs were issued.
- R13: Every PRECHARGE has `sd_addr[10]` high, and `xfer_done` and `yield_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the SDRAM clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cl3 | input | 1 | CAS latency select: 1 for 3, 0 for 2; static while busy |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Engine idle and able to take a job |
| job_row | input | 13 | Start row |
| job_col | input | 9 | Start column, low two bits ignored |
| job_bank | input | 2 | Bank to read |
| job_bursts | input | 8 | Number of bursts minus one |
| sink_room | input | 1 | Sink can absorb further bursts |
| arb_req | output | 1 | Bus request to the arbiter |
| arb_grant | input | 1 | Bus grant from the arbiter |
| refresh_pending | input | 1 | A refresh is waiting for the bus |
| yield_pulse | output | 1 | One-cycle pulse: bus released before the job ended |
| xfer_done | output | 1 | One-cycle pulse: job finished and bus released |
| sd_cmd | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| sd_addr | output | 13 | Row, column or precharge-all address |
| sd_bank | output | 2 | Bank address |
| sd_dq | input | 16 | Data bus from the SDRAM (never driven by this block) |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 16 | Read word |

## Verification
The hardest condition to reach is a yield that falls on a row edge or inside the activate-to-read wait. Resuming there has to re-open the correct row and pick up the exact column, and nothing at the ports shows the saved cursor. The bench makes the arbiter grant at random and raises refresh or drops sink room after a random delay. A model memory then returns address-dependent data and checks each command's row and column against an independently advanced pointer. Directed jobs start near column 508 and at row 8191 so that turns and wraps meet these interruptions.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
  typedef logic [3:0] sdcmd_t;

  localparam sdcmd_t SDC_NOP  = 4'b0111;
  localparam sdcmd_t SDC_ACT  = 4'b0011;
  localparam sdcmd_t SDC_READ = 4'b0101;
  localparam sdcmd_t SDC_PRE  = 4'b0010;

  localparam int BURST_LEN = 4;
  localparam int AP_BIT    = 10;

  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_RCD, ST_BURST, ST_TRP} rd_state_e;
  typedef enum logic [1:0] {NX_DONE, NX_BREAK, NX_TURN} after_pre_e;
endpackage

// File: rtl/sdram_rd_cursor.sv
module sdram_rd_cursor
  import sdram_rd_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ROW_W-1:0]  ld_row,
  input  logic [COL_W-1:0]  ld_col,
  input  logic [BANK_W-1:0] ld_bank,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              step,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic [BANK_W-1:0] bank,
  output logic              last,
  output logic              edge_hit
);
  localparam logic [COL_W-1:0] COL_STEP = COL_W'(BURST_LEN);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'((1 << COL_W) - BURST_LEN);
  localparam logic [COL_W-1:0] COL_MASK = ~COL_W'(BURST_LEN - 1);

  logic [LEN_W:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row  <= '0;
      col  <= '0;
      bank <= '0;
      left <= '0;
    end else if (load) begin
      row  <= ld_row;
      col  <= ld_col & COL_MASK;
      bank <= ld_bank;
      left <= {1'b0, ld_len} + 1'b1;
    end else if (step) begin
      col  <= col + COL_STEP;
      if (col == COL_LAST) row <= row + 1'b1;
      left <= left - 1'b1;
    end
  end

  assign last     = (left == '0);
  assign edge_hit = (col == '0);

  // R12
  no_overstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (left != '0));
  // R6
  col_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col & ~COL_MASK) == '0);
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat_live,
  input  logic            cl3,
  input  logic [DQ_W-1:0] dq_in,
  output logic [DQ_W-1:0] rd_data,
  output logic            rd_valid
);
  localparam int MAX_CL = 3;

  logic [MAX_CL-1:0] live_q;
  logic              tap;

  assign tap = cl3 ? live_q[MAX_CL-1] : live_q[MAX_CL-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      live_q   <= {live_q[MAX_CL-2:0], beat_live};
      rd_valid <= tap;
      if (tap) rd_data <= dq_in;
    end
  end

  // R7
  data_align3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cl3 && rd_valid) |-> $past(beat_live, 4));
  // R7
  data_align2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cl3 && rd_valid) |-> $past(beat_live, 3));
endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int TRCD   = 3,
  parameter int TRP    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              job_go,
  input  logic              arb_grant,
  input  logic              refresh_pending,
  input  logic              sink_room,
  input  logic [ROW_W-1:0]  cur_row,
  input  logic [COL_W-1:0]  cur_col,
  input  logic              cur_last,
  input  logic              cur_edge,
  output sdcmd_t            cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              arb_req,
  output logic              brk,
  output logic              done,
  output logic              idle,
  output logic              step,
  output logic              beat_live
);
  localparam int TMAX = (TRCD > TRP) ? TRCD : TRP;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << AP_BIT;

  rd_state_e  st;
  after_pre_e nxt;
  logic [TW-1:0] tcnt;
  logic [1:0]    beat;

  logic take, boundary, hold_off, rcd_ok, more;
  logic [ADDR_W-1:0] act_addr, rd_addr;

  assign arb_req   = (st == ST_REQ) && sink_room;
  assign take      = arb_req && arb_grant;
  assign boundary  = (st == ST_BURST) && (beat == 2'd3);
  assign hold_off  = refresh_pending || !sink_room;
  assign rcd_ok    = (st == ST_RCD) && (tcnt == TW'(TRCD));
  assign more      = boundary && !cur_last && !hold_off && !cur_edge;
  assign step      = rcd_ok || more;
  assign beat_live = (st == ST_BURST);
  assign idle      = (st == ST_IDLE);
  assign act_addr  = ADDR_W'(cur_row);
  assign rd_addr   = ADDR_W'(cur_col);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      nxt  <= NX_DONE;
      tcnt <= '0;
      beat <= '0;
      cmd  <= SDC_NOP;
      addr <= '0;
      brk  <= 1'b0;
      done <= 1'b0;
    end else begin
      cmd  <= SDC_NOP;
      addr <= '0;
      brk  <= 1'b0;
      done <= 1'b0;
      case (st)
        ST_IDLE: if (job_go) st <= ST_REQ;
        ST_REQ: begin
          if (take) begin
            cmd  <= SDC_ACT;
            addr <= act_addr;
            st   <= ST_RCD;
            tcnt <= TW'(1);
          end
        end
        ST_RCD: begin
          if (rcd_ok) begin
            cmd  <= SDC_READ;
            addr <= rd_addr;
            st   <= ST_BURST;
            beat <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_BURST: begin
          beat <= beat + 1'b1;
          if (more) begin
            cmd  <= SDC_READ;
            addr <= rd_addr;
          end else if (boundary) begin
            cmd  <= SDC_PRE;
            addr <= PRE_ADDR;
            st   <= ST_TRP;
            tcnt <= TW'(1);
            if (cur_last)      nxt <= NX_DONE;
            else if (hold_off) nxt <= NX_BREAK;
            else               nxt <= NX_TURN;
          end
        end
        ST_TRP: begin
          if (tcnt == TW'(TRP)) begin
            case (nxt)
              NX_DONE: begin
                done <= 1'b1;
                st   <= ST_IDLE;
              end
              NX_BREAK: begin
                brk <= 1'b1;
                st  <= ST_REQ;
              end
              default: begin
                cmd  <= SDC_ACT;
                addr <= act_addr;
                st   <= ST_RCD;
                tcnt <= TW'(1);
              end
            endcase
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // cycles since the last ACTIVE on the bus, saturating at TRCD
  logic [TW-1:0] act_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   act_age <= '0;
    else if (cmd == SDC_ACT)                      act_age <= TW'(1);
    else if (act_age != '0 && act_age < TW'(TRCD)) act_age <= act_age + 1'b1;
  end

  // R2
  legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == SDC_NOP || cmd == SDC_ACT || cmd == SDC_READ || cmd == SDC_PRE);
  // R5
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == SDC_READ) |-> (act_age == TW'(TRCD)));
  // R6
  read_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == SDC_READ) |-> ($past(cmd, 1) != SDC_READ && $past(cmd, 2) != SDC_READ
                           && $past(cmd, 3) != SDC_READ));
  // R13
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == SDC_PRE) |-> addr[AP_BIT]);
  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_req && arb_grant) |=> !arb_req);
  // R13
  single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk && done));
  // R10
  room_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sink_room |-> !arb_req);
endmodule

// File: rtl/sdram_burst_reader.sv
module sdram_burst_reader
  import sdram_rd_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int LEN_W  = 8,
  parameter int DQ_W   = 16,
  parameter int TRCD   = 3,
  parameter int TRP    = 2,
  parameter int ADDR_W = (ROW_W > 11) ? ROW_W : 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cl3,
  input  logic              job_valid,
  output logic              job_ready,
  input  logic [ROW_W-1:0]  job_row,
  input  logic [COL_W-1:0]  job_col,
  input  logic [BANK_W-1:0] job_bank,
  input  logic [LEN_W-1:0]  job_bursts,
  input  logic              sink_room,
  output logic              arb_req,
  input  logic              arb_grant,
  input  logic              refresh_pending,
  output logic              yield_pulse,
  output logic              xfer_done,
  output logic [3:0]        sd_cmd,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_bank,
  input  logic [DQ_W-1:0]   sd_dq,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data
);
  logic job_go, idle, step, beat_live, cur_last, cur_edge;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  sdcmd_t cmd;

  assign job_ready = idle;
  assign job_go    = job_valid && idle;
  assign sd_cmd    = cmd;

  sdram_rd_cursor #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .LEN_W(LEN_W)) u_cursor (
    .clk(clk), .rst_n(rst_n), .load(job_go), .ld_row(job_row), .ld_col(job_col),
    .ld_bank(job_bank), .ld_len(job_bursts), .step(step), .row(cur_row), .col(cur_col),
    .bank(sd_bank), .last(cur_last), .edge_hit(cur_edge)
  );

  sdram_rd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .TRCD(TRCD), .TRP(TRP)) u_seq (
    .clk(clk), .rst_n(rst_n), .job_go(job_go), .arb_grant(arb_grant),
    .refresh_pending(refresh_pending), .sink_room(sink_room), .cur_row(cur_row),
    .cur_col(cur_col), .cur_last(cur_last), .cur_edge(cur_edge), .cmd(cmd), .addr(sd_addr),
    .arb_req(arb_req), .brk(yield_pulse), .done(xfer_done), .idle(idle), .step(step),
    .beat_live(beat_live)
  );

  sdram_rd_capture #(.DQ_W(DQ_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .beat_live(beat_live), .cl3(cl3), .dq_in(sd_dq),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R3
  job_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && job_ready) |=> !job_ready);
  // R1
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_ready |-> (sd_cmd == SDC_NOP || xfer_done || $past(xfer_done) == 1'b0));
endmodule

// File: tb/test_sdram_burst_reader.sv
module test_sdram_burst_reader;
  localparam int CLK_P = 10;
  localparam int TRCD  = 3;
  localparam int TRP   = 2;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101, C_PRE = 4'b0010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cl3 = 1'b1, job_valid = 1'b0, sink_room = 1'b1, arb_grant = 1'b0, refresh_pending = 1'b0;
  logic [12:0] job_row = '0;
  logic [8:0]  job_col = '0;
  logic [1:0]  job_bank = '0;
  logic [7:0]  job_bursts = '0;
  logic [15:0] sd_dq = 16'hBAD0;
  logic job_ready, arb_req, yield_pulse, xfer_done, rd_valid;
  logic [3:0]  sd_cmd;
  logic [12:0] sd_addr;
  logic [1:0]  sd_bank;
  logic [15:0] rd_data;

  sdram_burst_reader i_sdram_burst_reader (
    .clk(clk), .rst_n(rst_n), .cl3(cl3), .job_valid(job_valid), .job_ready(job_ready),
    .job_row(job_row), .job_col(job_col), .job_bank(job_bank), .job_bursts(job_bursts),
    .sink_room(sink_room), .arb_req(arb_req), .arb_grant(arb_grant),
    .refresh_pending(refresh_pending), .yield_pulse(yield_pulse), .xfer_done(xfer_done),
    .sd_cmd(sd_cmd), .sd_addr(sd_addr), .sd_bank(sd_bank), .sd_dq(sd_dq),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] dval(input int bank, input int row, input int col);
    return 16'((row * 37) ^ (col * 5) ^ (bank << 14) ^ 16'h5A3C);
  endfunction

  // expectation and model state
  int j_bank, j_reads, e_rrow, e_rcol, e_wrow, e_wcol;
  int reads_seen, words_seen, acts, act_c, last_rd_c, pre_c, act_row, ref_reads, brk_total;
  bit first_rd, pend_pre, ref_on, done_seen, brk_seen, prev_rg, arb_en = 1'b1;
  bit sv[16];
  logic [15:0] sdat[16];

  initial begin
    for (int i = 0; i < 16; i++) sv[i] = 1'b0;
    brk_total = 0; acts = 0; pend_pre = 0; prev_rg = 0; ref_on = 0;
  end

  // memory model, arbiter and protocol monitor, all away from the active edge
  always @(negedge clk) begin
    int slot, cl;
    slot = cyc % 16;
    if (sv[slot]) begin sd_dq = sdat[slot]; sv[slot] = 1'b0; end
    else sd_dq = 16'hBAD0;
    if (rst_n) begin
      cl = cl3 ? 3 : 2;
      case (sd_cmd)
        C_ACT: begin
          act_row = int'(sd_addr);
          if (pend_pre) chk(cyc - pre_c == TRP, "R8 act after row-turn precharge gap", cyc - pre_c, TRP);
          pend_pre = 0;
          chk(act_row == e_rrow, "R11 activated row", act_row, e_rrow);
          first_rd = 1; act_c = cyc; acts++;
        end
        C_RD: begin
          if (first_rd) chk(cyc - act_c == TRCD, "R5 act to read gap", cyc - act_c, TRCD);
          else chk(cyc - last_rd_c == 4, "R6 read spacing", cyc - last_rd_c, 4);
          first_rd = 0; last_rd_c = cyc;
          chk(int'(sd_addr[8:0]) == e_rcol, "R6 read column", int'(sd_addr[8:0]), e_rcol);
          chk(sd_addr[10] == 1'b0, "R6 read A10 low", int'(sd_addr[10]), 0);
          chk(int'(sd_bank) == j_bank, "R6 bank", int'(sd_bank), j_bank);
          chk(act_row == e_rrow, "R8 open row for read", act_row, e_rrow);
          for (int k = 0; k < 4; k++) begin
            sv[(cyc + cl + k) % 16] = 1'b1;
            sdat[(cyc + cl + k) % 16] = dval(int'(sd_bank), act_row, int'(sd_addr[8:0]) + k);
          end
          e_rcol = e_rcol + 4;
          if (e_rcol == 512) begin e_rcol = 0; e_rrow = (e_rrow + 1) % 8192; end
          reads_seen++;
          if (ref_on) ref_reads++;
        end
        C_PRE: begin
          chk(sd_addr[10] == 1'b1, "R13 precharge A10 high", int'(sd_addr[10]), 1);
          pre_c = cyc; pend_pre = 1;
        end
        C_NOP: ;
        default: chk(0, "R2 illegal command", int'(sd_cmd), int'(C_NOP));
      endcase
      if (xfer_done || yield_pulse)
        chk(!(xfer_done && yield_pulse), "R13 done and yield together", 1, 0);
      if (xfer_done) begin
        chk(cyc - pre_c == TRP, "R12 done after precharge", cyc - pre_c, TRP);
        chk(reads_seen == j_reads, "R12 read count", reads_seen, j_reads);
        pend_pre = 0; done_seen = 1;
      end
      if (yield_pulse) begin
        chk(cyc - pre_c == TRP, "R9 yield after precharge", cyc - pre_c, TRP);
        pend_pre = 0; brk_seen = 1; brk_total++;
      end
      if (rd_valid) begin
        chk(rd_data == dval(j_bank, e_wrow, e_wcol), "R7 read word", int'(rd_data),
            int'(dval(j_bank, e_wrow, e_wcol)));
        e_wcol++;
        if (e_wcol == 512) begin e_wcol = 0; e_wrow = (e_wrow + 1) % 8192; end
        words_seen++;
      end
      if (prev_rg) chk(!arb_req, "R4 request drops after grant", int'(arb_req), 0);
      arb_grant = arb_req && arb_en && !refresh_pending && ($urandom % 3 != 0);
      prev_rg = arb_req && arb_grant;
    end
  end

  task automatic run_job(input int row, input int col, input int n, input bit c3,
                         input int ev_at, input bit ev_room);
    int t, ev_state, hold;
    do begin @(posedge clk); #2; end while (!job_ready);
    cl3 = c3;
    j_bank = $urandom % 4; j_reads = n + 1;
    e_rrow = row; e_rcol = col & ~3; e_wrow = row; e_wcol = col & ~3;
    reads_seen = 0; words_seen = 0; acts = 0; done_seen = 0; brk_seen = 0;
    job_row = 13'(row); job_col = 9'(col); job_bank = 2'(j_bank); job_bursts = 8'(n);
    job_valid = 1'b1;
    @(posedge clk); #2;
    job_valid = 1'b0;
    chk(!job_ready, "R3 busy after accept", int'(job_ready), 0);
    t = 0; ev_state = 0; hold = 0;
    while (!done_seen && t < 5000) begin
      @(posedge clk); #2; t++;
      if (ev_state == 0 && ev_at >= 0 && t == ev_at) begin
        if (ev_room) sink_room = 1'b0;
        else begin refresh_pending = 1'b1; arb_en = 1'b0; end
        ev_state = 1;
      end else if (ev_state == 1) begin
        ref_reads = 0; ref_on = 1; ev_state = 2;
      end else if (ev_state == 2) begin
        if (brk_seen) begin
          chk(ref_reads <= 1, ev_room ? "R10 reads after room low" : "R9 reads after refresh",
              ref_reads, 1);
          ref_on = 0; ev_state = 3; hold = 0;
        end else if (t - ev_at > 40) ev_state = 3;
      end else if (ev_state == 3) begin
        hold++;
        if (ev_room) chk(!arb_req, "R10 no request while sink full", int'(arb_req), 0);
        if (hold == 6) begin
          refresh_pending = 1'b0; sink_room = 1'b1; arb_en = 1'b1; ref_on = 0; ev_state = 4;
        end
      end
    end
    refresh_pending = 1'b0; sink_room = 1'b1; arb_en = 1'b1; ref_on = 0;
    chk(done_seen, "R12 job completed", int'(done_seen), 1);
    repeat (8) @(posedge clk);
    #2;
    chk(words_seen == (n + 1) * 4, "R11 words delivered", words_seen, (n + 1) * 4);
  endtask

  initial begin
    int seed, b0;
    seed = $urandom(32'd4242);
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    chk(sd_cmd == C_NOP, "R1 reset command", int'(sd_cmd), int'(C_NOP));
    chk(!arb_req && !rd_valid && !xfer_done && !yield_pulse, "R1 reset outputs quiet", 1, 0);
    chk(job_ready, "R1 ready after reset", int'(job_ready), 1);

    run_job(5, 0, 3, 1'b1, -1, 1'b0);
    run_job(9, 500, 5, 1'b0, -1, 1'b0);
    chk(acts == 2, "R8 row turn activates twice", acts, 2);
    run_job(8191, 508, 1, 1'b1, -1, 1'b0);
    chk(acts == 2, "R8 row wrap to zero", acts, 2);
    run_job(3, 7, 2, 1'b0, -1, 1'b0);
    b0 = brk_total;
    run_job(100, 0, 40, 1'b1, 15, 1'b0);
    chk(brk_total > b0, "R9 refresh causes yield", brk_total - b0, 1);
    b0 = brk_total;
    run_job(200, 256, 40, 1'b0, 15, 1'b1);
    chk(brk_total > b0, "R10 full sink causes yield", brk_total - b0, 1);
    run_job(40, 496, 10, 1'b1, 12, 1'b0);

    for (int i = 0; i < 14; i++) begin
      run_job($urandom % 8192, $urandom % 512, $urandom % 12, 1'(($urandom % 2)),
              ($urandom % 3 == 0) ? 5 + $urandom % 20 : -1, 1'(($urandom % 2)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule